// File: doc/BRIEF.md
# Rolling Four-Activate Window Limiter

This block sits beside a DDR2 command scheduler and decides, cycle by cycle, whether a bank-activate command may be sent to the memory. Parts with eight banks forbid more than four activates inside any rolling window of W clocks. W is the four-activate window time divided by the clock period, rounded up to the next whole clock. The scheduler presents an activate request. In the same cycle the block answers with either a grant or a stall.

The block records the issue cycle of each granted activate in a ring of four timestamps, taken from a free-running cycle counter. A request is granted when fewer than four recorded activates are still inside the window. An entry is outside the window once its age has reached W clocks. A denied request leaves no trace. The scheduler may hold it and retry on later cycles. A mode input turns the limit off for four-bank parts. W is a runtime input and may change at any time.

Top module: `act_window_guard`

## Requirements
- R1: After a synchronous active-low reset the history is empty: with no request both outputs are 0, and the first four requests are granted on consecutive cycles.
- R2: With the limit on and four activates granted at cycles A1 < A2 < A3 < A4, a request at a cycle N with N - A1 < W is stalled (act_stall=1, act_grant=0).
- R3: An activate at cycle N no longer counts from cycle N+W onward. A fifth request at exactly A1+W is granted, provided no other activate has been granted since A4.
- R4: With no request both outputs are 0. The outputs act_grant and act_stall are never 1 in the same cycle.
- R5: A stalled request is not recorded: it neither occupies a history entry nor delays later grants.
- R6: With limit_en=0 every request is granted and none is stalled. Activates granted in this mode are still recorded, and they count against the window once limit_en returns to 1.
- R7: win_len is used combinationally in the cycle it is presented. A value of 0 disables the limit. A value above MAX_WIN is treated as MAX_WIN.
- R8: The window slides: over a long run with irregular spacing, every grant and stall matches the rule that at most four granted activates lie in the last W cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_req | input | 1 | An activate wants to issue this cycle |
| win_len | input | $clog2(MAX_WIN+1)+1 | Window length W in clocks |
| limit_en | input | 1 | 1 applies the four-activate limit (eight-bank part), 0 bypasses it |
| act_grant | output | 1 | The activate may issue this cycle |
| act_stall | output | 1 | The activate is held back this cycle |

## Verification
Assertions check on every cycle that grant and stall never both rise, that a stall only answers a request while the limit is on, that a stall coincides with four live entries, that the slot a grant overwrites is no longer inside the window, and that no stored timestamp ages past MAX_WIN. Only the bench's scenarios can show the exact cycle of release at A1+W, the sliding behaviour under irregular spacing, and that a denied request leaves no trace. The same holds for the carry-over of activates granted in bypass mode, and for the clamping of an oversized window and a window shrunk at runtime.

// File: rtl/awg_pkg.sv
// Package: shared defaults and helpers for the activate window guard.
// Assumes widths are derived by the modules that use these constants.
package awg_pkg;
    localparam int ACT_LIMIT_DEF = 4;
    localparam int MAX_WIN_DEF   = 63;

    // Width of the timestamp counter for a given maximum window.
    function automatic int stamp_width(input int max_win);
        return $clog2(max_win + 1) + 1;
    endfunction
endpackage

// File: rtl/awg_tick.sv
// Module: free-running cycle counter used as the timestamp source.
// Assumes wrap-around is harmless because no stored stamp is kept
// longer than MAX_WIN cycles, which is below 2**CNT_W.
module awg_tick #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] now
);
    // Advance the cycle count every clock; restart at zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end
endmodule

// File: rtl/awg_slot.sv
// Module: one history entry holding the issue cycle of a granted activate.
// Reports whether that activate still lies inside the current window.
// Assumes win_eff <= MAX_WIN. The entry retires itself once its age reaches
// MAX_WIN, so its modular age never wraps.
module awg_slot #(
    parameter int CNT_W   = 7,
    parameter int MAX_WIN = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] now,
    input  logic [CNT_W-1:0] win_eff,
    input  logic             load,
    output logic             live
);
    localparam logic [CNT_W-1:0] MAX_AGE = CNT_W'(MAX_WIN);

    logic             valid_q;
    logic [CNT_W-1:0] stamp_q;
    logic [CNT_W-1:0] age;

    // Age of the stored activate relative to the current cycle.
    always_comb age = now - stamp_q;

    // Entry counts against the window while its age is below W.
    always_comb live = valid_q && (age < win_eff);

    // Capture a new stamp on load; retire the entry once it reaches MAX_WIN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            stamp_q <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            stamp_q <= now;
        end else if (valid_q && age >= MAX_AGE) begin
            valid_q <= 1'b0;
        end
    end

    // R8: a held stamp never ages past MAX_WIN, so modular age stays exact.
    p_age_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (age <= MAX_AGE));

    // R1: reset leaves the entry empty.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> !valid_q);
endmodule

// File: rtl/act_window_guard.sv
// Module: grants or stalls bank-activate requests so that at most ACT_LIMIT
// granted activates lie within any rolling window of win_len clocks.
// Assumes the caller issues an activate only in a cycle where act_grant is 1.
// Grants are recorded even while limit_en is 0.
module act_window_guard
    import awg_pkg::*;
#(
    parameter int ACT_LIMIT = ACT_LIMIT_DEF,
    parameter int MAX_WIN   = MAX_WIN_DEF,
    localparam int CNT_W    = stamp_width(MAX_WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_req,
    input  logic [CNT_W-1:0] win_len,
    input  logic             limit_en,
    output logic             act_grant,
    output logic             act_stall
);
    localparam int PTR_W = (ACT_LIMIT > 1) ? $clog2(ACT_LIMIT) : 1;
    localparam int NUM_W = $clog2(ACT_LIMIT + 1);
    localparam logic [CNT_W-1:0] WIN_CAP  = CNT_W'(MAX_WIN);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ACT_LIMIT - 1);

    logic [CNT_W-1:0]     now;
    logic [CNT_W-1:0]     win_eff;
    logic [ACT_LIMIT-1:0] live;
    logic [ACT_LIMIT-1:0] load;
    logic [PTR_W-1:0]     wr_ptr;
    logic [NUM_W-1:0]     n_live;
    logic                 room;

    awg_tick #(.CNT_W(CNT_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .now   (now)
    );

    // Clamp the requested window to the largest supported length.
    always_comb win_eff = (win_len > WIN_CAP) ? WIN_CAP : win_len;

    generate
        for (genvar i = 0; i < ACT_LIMIT; i++) begin : g_slot
            awg_slot #(.CNT_W(CNT_W), .MAX_WIN(MAX_WIN)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .now     (now),
                .win_eff (win_eff),
                .load    (load[i]),
                .live    (live[i])
            );
        end
    endgenerate

    // Count the activates that still fall inside the window.
    always_comb begin
        n_live = '0;
        for (int i = 0; i < ACT_LIMIT; i++) n_live = n_live + NUM_W'(live[i]);
    end

    // Room exists while fewer than ACT_LIMIT activates are live.
    always_comb room = (n_live < NUM_W'(ACT_LIMIT));

    // Grant or stall the request in the cycle it is presented.
    always_comb begin
        act_grant = act_req && (!limit_en || room);
        act_stall = act_req && limit_en && !room;
    end

    // Steer the grant into the oldest entry of the ring.
    always_comb begin
        load = '0;
        if (act_grant) load[wr_ptr] = 1'b1;
    end

    // Advance the ring pointer once per granted activate.
    always_ff @(posedge clk) begin
        if (!rst_n)         wr_ptr <= '0;
        else if (act_grant) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
    end

    // R4: grant and stall are mutually exclusive.
    p_grant_xor_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_grant && act_stall));

    // R4: a stall only answers a pending request.
    p_stall_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_stall |-> act_req);

    // R6: the bypass mode never stalls.
    p_bypass_no_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !limit_en |-> !act_stall);

    // R2: a stall happens only with every entry still live.
    p_stall_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act_stall |-> ($countones(live) == ACT_LIMIT));

    // R3: with the limit on, a grant never overwrites a live activate.
    p_victim_expired_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_grant && limit_en) |-> !live[wr_ptr]);
endmodule

// File: tb/act_window_guard_test.sv
module act_window_guard_test;
    localparam int CW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          act_req = 1'b0;
    logic [CW-1:0] win_len = '0;
    logic          limit_en = 1'b1;
    logic          act_grant;
    logic          act_stall;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    act_window_guard uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_req   (act_req),
        .win_len   (win_len),
        .limit_en  (limit_en),
        .act_grant (act_grant),
        .act_stall (act_stall)
    );

    // Vector fields: {req, limit_en, win[6:0], exp_grant, exp_stall}. W = 6 (R8, R2, R3, R5).
    localparam logic [10:0] VEC [18] = '{
        {1'b1, 1'b1, 7'd6, 1'b1, 1'b0},  // c0 grant
        {1'b1, 1'b1, 7'd6, 1'b1, 1'b0},  // c1 grant
        {1'b0, 1'b1, 7'd6, 1'b0, 1'b0},  // c2 idle
        {1'b1, 1'b1, 7'd6, 1'b1, 1'b0},  // c3 grant
        {1'b1, 1'b1, 7'd6, 1'b1, 1'b0},  // c4 grant, four held
        {1'b1, 1'b1, 7'd6, 1'b0, 1'b1},  // c5 stall
        {1'b1, 1'b1, 7'd6, 1'b1, 1'b0},  // c6 c0 aged out
        {1'b1, 1'b1, 7'd6, 1'b1, 1'b0},  // c7 c1 aged out
        {1'b1, 1'b1, 7'd6, 1'b0, 1'b1},  // c8 stall
        {1'b0, 1'b1, 7'd6, 1'b0, 1'b0},  // c9 idle
        {1'b1, 1'b1, 7'd6, 1'b1, 1'b0},  // c10 c3 aged out
        {1'b1, 1'b1, 7'd6, 1'b1, 1'b0},  // c11 c4 aged out
        {1'b1, 1'b1, 7'd6, 1'b1, 1'b0},  // c12 c6 aged out
        {1'b1, 1'b1, 7'd6, 1'b1, 1'b0},  // c13 c7 aged out
        {1'b1, 1'b1, 7'd6, 1'b0, 1'b1},  // c14 stall
        {1'b1, 1'b1, 7'd6, 1'b0, 1'b1},  // c15 stall
        {1'b1, 1'b1, 7'd6, 1'b1, 1'b0},  // c16 c10 aged out
        {1'b0, 1'b0, 7'd6, 1'b0, 1'b0}   // c17 no request
    };

    task automatic check(input logic eg, input logic es, input string tag);
        checks++;
        if (act_grant !== eg || act_stall !== es) begin
            errors++;
            $display("FAIL %s: grant/stall actual %b%b expected %b%b at %0t",
                     tag, act_grant, act_stall, eg, es, $time);
        end
    endtask

    task automatic step(input logic r, input logic e, input logic [CW-1:0] w,
                        input logic eg, input logic es, input string tag);
        @(negedge clk);
        act_req = r; limit_en = e; win_len = w;
        #2;
        check(eg, es, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; act_req = 1'b0; limit_en = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(1'b0, 1'b0, "R1 reset idle");
    endtask

    initial begin
        do_reset();
        // R8 table walk
        for (int i = 0; i < 18; i++)
            step(VEC[i][10], VEC[i][9], VEC[i][8:2], VEC[i][1], VEC[i][0], "R8 vector");

        // R1, R2, R3, R5: held request with W = 20
        do_reset();
        for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 7'd20, 1'b1, 1'b0, "R1 first four");
        for (int k = 4; k < 20; k++) step(1'b1, 1'b1, 7'd20, 1'b0, 1'b1, "R2 inside window");
        step(1'b1, 1'b1, 7'd20, 1'b1, 1'b0, "R3 release at A1+W");
        step(1'b1, 1'b1, 7'd20, 1'b1, 1'b0, "R5 stalls not recorded");
        step(1'b1, 1'b1, 7'd20, 1'b1, 1'b0, "R5 stalls not recorded");
        step(1'b1, 1'b1, 7'd20, 1'b1, 1'b0, "R5 stalls not recorded");
        step(1'b1, 1'b1, 7'd20, 1'b0, 1'b1, "R2 window full again");
        step(1'b0, 1'b1, 7'd20, 1'b0, 1'b0, "R4 no request");

        // R6: bypass grants everything, grants still recorded
        do_reset();
        for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 7'd20, 1'b1, 1'b0, "R6 bypass grant");
        step(1'b1, 1'b1, 7'd20, 1'b0, 1'b1, "R6 bypass grants counted");
        // R7: window of zero disables the limit
        step(1'b1, 1'b1, 7'd0, 1'b1, 1'b0, "R7 zero window");

        // R7: oversized window clamped to 63
        do_reset();
        for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 7'd100, 1'b1, 1'b0, "R7 fill");
        for (int k = 4; k < 62; k++) step(1'b0, 1'b1, 7'd100, 1'b0, 1'b0, "R4 idle");
        step(1'b1, 1'b1, 7'd100, 1'b0, 1'b1, "R7 clamp inside");
        step(1'b1, 1'b1, 7'd100, 1'b1, 1'b0, "R7 clamp release at 63");

        // R7: shrinking the window at runtime releases at once
        do_reset();
        for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 7'd63, 1'b1, 1'b0, "R7 fill");
        for (int k = 4; k < 10; k++) step(1'b0, 1'b1, 7'd63, 1'b0, 1'b0, "R4 idle");
        step(1'b1, 1'b1, 7'd63, 1'b0, 1'b1, "R7 long window stalls");
        step(1'b1, 1'b1, 7'd10, 1'b1, 1'b0, "R7 shrunk window grants");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule